// File: doc/BRIEF.md
# SPI Memory Command Front End

This block is the slave side of a four-wire serial link in modes 0 and 3, placed in front of a byte-wide memory with a 17-bit address space. The host lowers chip select and clocks in an opcode byte. The block then reads or writes the memory with no wait states, reports and updates a small status register, and sets or clears a write-enable latch. For the four nonvolatile control opcodes it sends a one-cycle request pulse to the neighbouring store/recall controller. While that controller signals busy, the block refuses memory transfers.

The serial pins are oversampled by the system clock `clk`. Each SCK half-period must last at least two `clk` cycles. A small on-chip array stands in for the memory. Its size is set by `ARRAY_AW`, and the array is indexed by the low `ARRAY_AW` bits of the 17-bit address, so addresses that differ only above those bits share a location. Writes are gated by the latch, by the busy signal and by a block-protect field that covers a quarter, a half or all of the array. A status-lock bit together with the write-protect pin guards the status register.

Top module: `spi_mem_front`

## Requirements
- R1: After reset the status register reads 0x00. The status byte is laid out as {lock, 0, 0, 0, bp[1:0], wel, busy} from bit 7 down to bit 0.
- R2: READ (0x03) followed by three address bytes returns data on `so` from the next falling SCK edge, MSB first, with no wait bits. The address increments for each further byte. This holds in both mode 0 and mode 3.
- R3: FAST_READ (0x0B) takes one ignored dummy byte after the address, and then streams data in the same way as READ.
- R4: WRITE (0x02) followed by three address bytes stores each later data byte at successive addresses, but only while the write-enable latch is set. WREN (0x06) sets the latch, WRDI (0x04) clears it, and its value reads as status bit 1.
- R5: The write-enable latch clears when chip select rises after a WRITE or WRSR opcode, whether or not the transfer completed.
- R6: A read or write burst continues from address 0x1FFFF to 0x00000.
- R7: Data bytes are not stored at protected addresses. bp=01 protects addresses 0x18000 and up, bp=10 protects 0x10000 and up, and bp=11 protects all addresses.
- R8: WRSR (0x01) with the latch set loads bp from data bits 3:2 and lock from bit 7. When lock is 1 and `wp_n` is low, WRSR has no effect.
- R9: While `hold_n` is low, SCK edges are ignored. After `hold_n` is released the transfer resumes at the same bit.
- R10: While `nv_busy` is high, status bit 0 reads 1 and READ, FAST_READ and WRITE sequences are refused.
- R11: STORE (0x3C), RECALL (0x60), autostore-on (0x59) and autostore-off (0x19) each raise their own request output for exactly one `clk` cycle.
- R12: Chip select high aborts any sequence. The next selection starts with a fresh opcode.
- R13: Address bits 23..17 are ignored.
- R14: `so_oe` is low whenever `cs_n` is high or `hold_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on the SCK rising edge |
| hold_n | input | 1 | Suspends the transfer while low |
| wp_n | input | 1 | Write-protect pin for the status register |
| nv_busy | input | 1 | Store/recall in progress |
| so | output | 1 | Serial data out, changes on the SCK falling edge |
| so_oe | output | 1 | Output enable for `so` |
| store_req | output | 1 | One-cycle store request |
| recall_req | output | 1 | One-cycle recall request |
| autostore_on | output | 1 | One-cycle autostore-enable request |
| autostore_off | output | 1 | One-cycle autostore-disable request |

## Verification
Reads are tried in five forms: plain, fast, in mode 3, burst across the top address, and with junk in the upper address byte. These separate correct dummy-byte handling, correct edge polarity, correct wraparound and correct address truncation. Writes are tried with and without the latch, under each block-protect setting at addresses on both sides of each boundary, while busy, and aborted mid-byte. Each case has a different expected read-back. Hold is applied in the middle of a byte during both a read and a write, so a lost or repeated bit shows up as a shifted byte.

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W   = 17,
  parameter int ARRAY_AW = 10,
  parameter logic [7:0] OP_STORE  = 8'h3C,
  parameter logic [7:0] OP_RECALL = 8'h60,
  parameter logic [7:0] OP_ASON   = 8'h59,
  parameter logic [7:0] OP_ASOFF  = 8'h19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  input  logic nv_busy,
  output logic so,
  output logic so_oe,
  output logic store_req,
  output logic recall_req,
  output logic autostore_on,
  output logic autostore_off
);
  localparam int DEPTH = 1 << ARRAY_AW;
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR  = 8'h05, OP_WREN = 8'h06,
                         OP_FAST = 8'h0B;

  typedef enum logic [2:0] {P_CMD, P_ADDR, P_DUMMY, P_DATA, P_SKIP} phase_t;

  phase_t phase;
  logic sck_q, so_q, wel, lock, have_op;
  logic [2:0] bitc;
  logic [1:0] abyte, bp;
  logic [6:0] sr;
  logic [7:0] op, tx;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];

  function automatic logic prot_f(input logic [1:0] b, input logic [ADDR_W-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  wire sck_rise  = !cs_n && hold_n && sck && !sck_q;
  wire sck_fall  = !cs_n && hold_n && !sck && sck_q;
  wire byte_done = sck_rise && (bitc == 3'd7);
  wire [7:0] rx  = {sr, si};
  wire [ADDR_W-1:0] addr_in = {addr[ADDR_W-9:0], rx};
  wire [7:0] status = {lock, 3'b000, bp, wel, nv_busy};
  wire is_rd  = (op == OP_READ) || (op == OP_FAST);
  wire mem_we = byte_done && phase == P_DATA && op == OP_WRITE &&
                wel && !nv_busy && !prot_f(bp, addr);

  assign so    = so_q;
  assign so_oe = !cs_n && hold_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;

  always_ff @(posedge clk)
    if (mem_we) mem[addr[ARRAY_AW-1:0]] <= rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_CMD; bitc <= '0; abyte <= '0; sr <= '0; op <= '0; tx <= '0;
      addr <= '0; so_q <= 1'b0; wel <= 1'b0; lock <= 1'b0; bp <= '0;
      have_op <= 1'b0; store_req <= 1'b0; recall_req <= 1'b0;
      autostore_on <= 1'b0; autostore_off <= 1'b0;
    end else begin
      store_req <= 1'b0; recall_req <= 1'b0;
      autostore_on <= 1'b0; autostore_off <= 1'b0;
      if (cs_n) begin
        phase <= P_CMD;
        bitc  <= '0;
        have_op <= 1'b0;
        if (have_op && (op == OP_WRITE || op == OP_WRSR)) wel <= 1'b0;
      end else if (sck_rise) begin
        sr   <= rx[6:0];
        bitc <= bitc + 3'd1;
        if (byte_done) begin
          case (phase)
            P_CMD: begin
              op <= rx;
              have_op <= 1'b1;
              phase <= P_SKIP;
              abyte <= '0;
              case (rx)
                OP_WREN:   wel <= 1'b1;
                OP_WRDI:   wel <= 1'b0;
                OP_RDSR:   begin phase <= P_DATA; tx <= status; end
                OP_WRSR:   phase <= P_DATA;
                OP_READ, OP_FAST, OP_WRITE: phase <= nv_busy ? P_SKIP : P_ADDR;
                OP_STORE:  store_req <= 1'b1;
                OP_RECALL: recall_req <= 1'b1;
                OP_ASON:   autostore_on <= 1'b1;
                OP_ASOFF:  autostore_off <= 1'b1;
                default:   ;
              endcase
            end
            P_ADDR: begin
              addr  <= addr_in;
              abyte <= abyte + 2'd1;
              if (abyte == 2'd2) begin
                if (op == OP_FAST) phase <= P_DUMMY;
                else begin
                  phase <= P_DATA;
                  if (op == OP_READ) begin
                    tx   <= mem[addr_in[ARRAY_AW-1:0]];
                    addr <= addr_in + ADDR_W'(1);
                  end
                end
              end
            end
            P_DUMMY: begin
              phase <= P_DATA;
              tx    <= mem[addr[ARRAY_AW-1:0]];
              addr  <= addr + ADDR_W'(1);
            end
            P_DATA: begin
              if (op == OP_WRITE) addr <= addr + ADDR_W'(1);
              else if (is_rd) begin
                tx   <= mem[addr[ARRAY_AW-1:0]];
                addr <= addr + ADDR_W'(1);
              end else if (op == OP_RDSR) tx <= status;
              else begin
                if (wel && !(lock && !wp_n)) begin
                  lock <= rx[7];
                  bp   <= rx[3:2];
                end
                phase <= P_SKIP;
              end
            end
            default: ;
          endcase
        end
      end else if (sck_fall && phase == P_DATA) begin
        so_q <= tx[7];
        tx   <= {tx[6:0], 1'b0};
      end
    end
  end

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == P_CMD && bitc == 3'd0));
  assert_wel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && have_op && (op == OP_WRITE || op == OP_WRSR)) |=> !wel);
  assert_all_protected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp != 2'b11));
  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> $stable(bitc));
  assert_busy_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && byte_done && phase == P_CMD && (rx == OP_READ || rx == OP_WRITE))
      |=> phase == P_SKIP);
  assert_store_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req, autostore_on, autostore_off}));
  assert_oe_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !hold_n) |-> !so_oe);
endmodule

// File: tb/tb_spi_mem_front.sv
module tb_spi_mem_front;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1, nv_busy = 0;
  logic so, so_oe, store_req, recall_req, autostore_on, autostore_off;

  spi_mem_front dut (.clk, .rst_n, .cs_n, .sck, .si, .hold_n, .wp_n, .nv_busy, .so, .so_oe,
                     .store_req, .recall_req, .autostore_on, .autostore_off);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_st = 0, n_rc = 0, n_on = 0, n_off = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  logic [7:0] ref_mem [1024];
  logic m_wel = 0, m_lock = 0, mode3 = 0;
  logic [1:0] m_bp = 0;
  int hold_byte = -1, byte_no = 0;

  always @(posedge clk) begin
    if (store_req) n_st++;
    if (recall_req) n_rc++;
    if (autostore_on) n_on++;
    if (autostore_off) n_off++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), 32'(act_q.pop_front()), 32'(exp_q.pop_front()));
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  function automatic logic prot(logic [16:0] a);
    case (m_bp)
      2'b00: return 0;
      2'b01: return a >= 17'h18000;
      2'b10: return a >= 17'h10000;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {m_lock, 3'b000, m_bp, m_wel, nv_busy};
  endfunction

  task automatic xfer(input logic [7:0] t, input int nb, output logic [7:0] r);
    r = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (byte_no == hold_byte && i == 4) begin
        hold_n = 0; tick(2);
        chk("R14 hold oe", 32'(so_oe), 0);
        sck = ~sck; tick(4); sck = ~sck; tick(4);
        hold_n = 1; tick(2);
      end
      sck = 0; si = t[i]; tick(4);
      r[i] = so;
      sck = 1; tick(4);
    end
    byte_no++;
  endtask

  task automatic cs_lo();
    sck = mode3; byte_no = 0; tick(2); cs_n = 0; tick(2);
  endtask
  task automatic cs_hi();
    sck = mode3; tick(4); cs_n = 1; tick(4); sck = 0;
  endtask

  task automatic cmd(logic [7:0] o);
    logic [7:0] r;
    cs_lo(); xfer(o, 8, r); cs_hi();
  endtask
  task automatic wren(); cmd(8'h06); m_wel = 1; endtask
  task automatic wrdi(); cmd(8'h04); m_wel = 0; endtask

  task automatic send_addr(logic [23:0] a);
    logic [7:0] r;
    xfer(a[23:16], 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
  endtask

  task automatic wr(logic [23:0] a, logic [7:0] base, int n);
    logic [7:0] r;
    logic [16:0] p = a[16:0];
    cs_lo(); xfer(8'h02, 8, r); send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = base + 8'(i * 8'h11);
      xfer(d, 8, r);
      if (m_wel && !nv_busy && !prot(p)) ref_mem[p[9:0]] = d;
      p = p + 17'd1;
    end
    cs_hi(); m_wel = 0;
  endtask

  task automatic rd(logic [23:0] a, int n, logic fast, string tag);
    logic [7:0] r;
    logic [16:0] p = a[16:0];
    cs_lo(); xfer(fast ? 8'h0B : 8'h03, 8, r); send_addr(a);
    if (fast) xfer(8'hA7, 8, r);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[p[9:0]]); tag_q.push_back(tag);
      xfer(8'h00, 8, r);
      act_q.push_back(r);
      p = p + 17'd1;
    end
    cs_hi();
  endtask

  task automatic rdsr(string tag);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, 8, r);
    for (int i = 0; i < 2; i++) begin
      exp_q.push_back(m_status()); tag_q.push_back(tag);
      xfer(8'h00, 8, r);
      act_q.push_back(r);
    end
    cs_hi();
  endtask

  task automatic wrsr(logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xfer(8'h01, 8, r); xfer(v, 8, r); cs_hi();
    if (m_wel && !(m_lock && !wp_n)) begin m_lock = v[7]; m_bp = v[3:2]; end
    m_wel = 0;
  endtask

  task automatic finish_run();
    tick(20);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    tick(5); rst_n = 1; tick(5);
    chk("R14 idle oe", 32'(so_oe), 0);
    rdsr("R1 reset status");

    wren(); rdsr("R4 wel set");
    wrdi(); rdsr("R4 wel cleared by WRDI");
    wren(); wr(24'h000040, 8'hA5, 1);
    rdsr("R5 wel cleared after write");
    wr(24'h000040, 8'h11, 1);
    rd(24'h000040, 1, 0, "R4 write without latch ignored");

    wren(); wr(24'h000100, 8'h30, 4);
    rd(24'h000100, 4, 0, "R2 burst read");
    rd(24'h000101, 3, 1, "R3 fast read");
    rd(24'hFE0102, 2, 0, "R13 upper address ignored");
    mode3 = 1; rd(24'h000100, 4, 0, "R2 mode 3 read"); mode3 = 0;

    wren(); wr(24'h01FFFE, 8'h5A, 3);
    rd(24'h01FFFF, 2, 0, "R6 wrap read");
    rd(24'h000000, 1, 0, "R6 wrap write landed at zero");

    hold_byte = 5; rd(24'h000100, 3, 0, "R9 hold in read");
    wren(); hold_byte = 4; wr(24'h000200, 8'hC3, 2); hold_byte = -1;
    rd(24'h000200, 2, 0, "R9 hold in write");

    wren(); wr(24'h018010, 8'h01, 1);
    wren(); wr(24'h017F20, 8'h02, 1);
    wren(); wr(24'h010030, 8'h03, 1);
    wren(); wr(24'h000050, 8'h04, 1);
    wren(); wrsr(8'h04); rdsr("R8 bp quarter loaded");
    wren(); wr(24'h018010, 8'hE1, 1);
    wren(); wr(24'h017F20, 8'hE2, 1);
    rd(24'h018010, 1, 0, "R7 quarter protects top");
    rd(24'h017F20, 1, 0, "R7 quarter leaves below");
    wren(); wrsr(8'h08);
    wren(); wr(24'h010030, 8'hE3, 1);
    wren(); wr(24'h00FF40, 8'hE4, 1);
    rd(24'h010030, 1, 0, "R7 half protects top");
    rd(24'h00FF40, 1, 0, "R7 half leaves below");
    wren(); wrsr(8'h0C);
    wren(); wr(24'h000050, 8'hE5, 1);
    rd(24'h000050, 1, 0, "R7 all protected");

    wren(); wrsr(8'h80); rdsr("R8 lock set");
    wp_n = 0; wren(); wrsr(8'h0C); rdsr("R8 locked status unchanged");
    wp_n = 1; wren(); wrsr(8'h00); rdsr("R8 unlocked status written");

    wren(); wr(24'h000060, 8'h66, 1);
    nv_busy = 1; tick(2);
    rdsr("R10 busy bit");
    wren(); wr(24'h000060, 8'h99, 1);
    nv_busy = 0; tick(2);
    rd(24'h000060, 1, 0, "R10 write refused while busy");

    cmd(8'h3C); chk("R11 store pulse", n_st, 1);
    cmd(8'h60); chk("R11 recall pulse", n_rc, 1);
    cmd(8'h59); chk("R11 autostore on pulse", n_on, 1);
    cmd(8'h19); chk("R11 autostore off pulse", n_off, 1);
    chk("R11 no cross pulse", n_st + n_rc + n_on, 3);

    cs_lo(); xfer(8'h05, 4, r); cs_hi();
    rdsr("R12 partial opcode aborted");
    wren();
    cs_lo(); xfer(8'h02, 8, r); send_addr(24'h000040); xfer(8'h77, 4, r); cs_hi();
    m_wel = 0;
    rd(24'h000040, 1, 0, "R12 aborted write byte dropped");
    rdsr("R5 wel cleared after aborted write");

    tick(10);
    finish_run();
  end
endmodule